// File: doc/BRIEF.md
# Load Reservation Tracker

This block keeps the single load-reserved address of one hart for a load-reserved / store-conditional pair. The pipeline sends it single-cycle pulses: one when a load-reserved executes, one when a store-conditional executes (each with its byte address), and one whenever the hart changes privilege mode. The block answers each store-conditional with a result code one cycle later. It does not perform the memory access and does not order memory.

The reservation is a valid bit and a word address. A load-reserved sets them. Every store-conditional, every mode change and, when the option is built in, an external invalidate clears the valid bit. This keeps a reservation from surviving into another context and from being used twice. Addresses are compared per naturally aligned word, so the low `GRAN_LSB` bits are ignored.

Top module: `lrsc_tracker`

## Requirements
- R1: After reset the reservation is invalid, `sc_resp_valid` is 0, and a store-conditional issued before any load-reserved reports failure (`sc_fail` = 1).
- R2: A store-conditional to the same word as a live reservation succeeds, reported as `sc_fail` = 0.
- R3: A store-conditional whose word differs from the reserved word fails (`sc_fail` = 1).
- R4: Every store-conditional clears the reservation, whatever its result and address. A following store-conditional to the reserved word therefore fails.
- R5: A pulse on `mode_chg` clears the reservation, so a later store-conditional fails.
- R6: When `lr_fire` and `mode_chg` are high in the same cycle, the reservation ends invalid.
- R7: A second load-reserved replaces the first. Only the newer word can then succeed.
- R8: Address bits below `GRAN_LSB` (default 2) take no part in the match. 0x300 and 0x303 match; 0x301 and 0x304 do not.
- R9: `sc_resp_valid` is high in exactly the cycle after a cycle with `sc_fire` high, and low otherwise.
- R10: With `USE_EXT_KILL` = 1 (the default), a pulse on `ext_kill` clears the reservation.
- R11: A store-conditional and a load-reserved in the same cycle: the store-conditional is judged against the reservation that existed before that cycle, and the reservation ends invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_fire | input | 1 | Load-reserved executes this cycle |
| lr_addr | input | ADDR_W | Byte address of the load-reserved |
| sc_fire | input | 1 | Store-conditional executes this cycle |
| sc_addr | input | ADDR_W | Byte address of the store-conditional |
| mode_chg | input | 1 | Privilege mode changes this cycle |
| ext_kill | input | 1 | External invalidate, for example a coherence event |
| sc_resp_valid | output | 1 | Result of a store-conditional is present |
| sc_fail | output | 1 | Result code: 0 success, 1 failure |

## Verification
A store-conditional result is due one clock after the `sc_fire` cycle, because it passes through one register. Clearing and setting the reservation also take effect at that edge, so the next operation sees the new state. The bench drives each pulse for one cycle from a falling edge and reads the result at the next falling edge, half a period after the result register loads. A reference model advances on the same rising edges and is compared with both outputs at every falling edge.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

   // result code carried on sc_fail
   typedef enum logic {
      SC_PASS = 1'b0,
      SC_FAIL = 1'b1
   } sc_code_e;

endpackage

// File: rtl/lrsc_word_cmp.sv
module lrsc_word_cmp #(
   parameter int WORD_W = 30
) (
   input  logic [WORD_W-1:0] held_word,
   input  logic [WORD_W-1:0] probe_word,
   output logic              same_word
);
   assign same_word = (held_word == probe_word);
endmodule

// File: rtl/lrsc_resv_store.sv
module lrsc_resv_store #(
   parameter int WORD_W = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [WORD_W-1:0] take_word,
   input  logic              drop,
   output logic              held,
   output logic [WORD_W-1:0] held_word
);
   // dropping beats taking when both arrive together
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_word <= '0;
      end else if (drop) begin
         held      <= 1'b0;
      end else if (take) begin
         held      <= 1'b1;
         held_word <= take_word;
      end
   end
endmodule

// File: rtl/lrsc_result_reg.sv
module lrsc_result_reg
   import lrsc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fire,
   input  logic     pass,
   output logic     resp_valid,
   output sc_code_e resp_code
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_code  <= SC_FAIL;
      end else begin
         resp_valid <= fire;
         if (fire) resp_code <= pass ? SC_PASS : SC_FAIL;
      end
   end
endmodule

// File: rtl/lrsc_tracker.sv
module lrsc_tracker
   import lrsc_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int GRAN_LSB     = 2,
   parameter bit USE_EXT_KILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lr_fire,
   input  logic [ADDR_W-1:0] lr_addr,
   input  logic              sc_fire,
   input  logic [ADDR_W-1:0] sc_addr,
   input  logic              mode_chg,
   input  logic              ext_kill,
   output logic              sc_resp_valid,
   output logic              sc_fail
);
   localparam int WORD_W = ADDR_W - GRAN_LSB;

   // elaboration-time parameter checks
   generate
      if (ADDR_W < 2 || GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad_param
         $error("lrsc_tracker: GRAN_LSB must lie in 0..ADDR_W-1");
      end
   endgenerate

   logic              kill_eff;
   logic              drop_now;
   logic              held;
   logic [WORD_W-1:0] held_word;
   logic              word_hit;
   sc_code_e          code_q;

   // optional external invalidate
   generate
      if (USE_EXT_KILL) begin : g_kill_on
         assign kill_eff = ext_kill;
      end else begin : g_kill_off
         logic unused_kill;
         assign unused_kill = ext_kill;
         assign kill_eff    = 1'b0;
      end
   endgenerate

   // bits under the match granule do not take part in any decision
   generate
      if (GRAN_LSB > 0) begin : g_low_bits
         logic unused_low;
         assign unused_low = ^{lr_addr[GRAN_LSB-1:0], sc_addr[GRAN_LSB-1:0]};
      end
   endgenerate

   assign drop_now = sc_fire | mode_chg | kill_eff;

   lrsc_resv_store #(.WORD_W(WORD_W)) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (lr_fire),
      .take_word (lr_addr[ADDR_W-1:GRAN_LSB]),
      .drop      (drop_now),
      .held      (held),
      .held_word (held_word)
   );

   lrsc_word_cmp #(.WORD_W(WORD_W)) cmp_i (
      .held_word  (held_word),
      .probe_word (sc_addr[ADDR_W-1:GRAN_LSB]),
      .same_word  (word_hit)
   );

   lrsc_result_reg res_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (sc_fire),
      .pass       (held & word_hit),
      .resp_valid (sc_resp_valid),
      .resp_code  (code_q)
   );

   assign sc_fail = (code_q == SC_FAIL);
endmodule

// File: rtl/lrsc_tracker_chk.sv
module lrsc_tracker_chk #(
   parameter int ADDR_W       = 32,
   parameter int GRAN_LSB     = 2,
   parameter bit USE_EXT_KILL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lr_fire,
   input logic [ADDR_W-1:0] lr_addr,
   input logic              sc_fire,
   input logic [ADDR_W-1:0] sc_addr,
   input logic              mode_chg,
   input logic              ext_kill,
   input logic              sc_resp_valid,
   input logic              sc_fail
);
   logic kill_seen;
   assign kill_seen = USE_EXT_KILL && ext_kill;

   // R9
   resp_follows_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sc_fire |=> sc_resp_valid);

   // R9
   no_stray_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sc_fire |=> !sc_resp_valid);

   // R4
   back_to_back_sc_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sc_fire ##1 sc_fire |=> sc_fail);

   // R5
   mode_chg_then_sc_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg ##1 sc_fire |=> sc_fail);

   // R10
   kill_then_sc_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_seen ##1 sc_fire |=> sc_fail);

   // R2 R3 R8
   lr_then_sc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lr_fire && !mode_chg && !sc_fire && !kill_seen) && sc_fire) |=>
      (sc_fail == ($past(lr_addr[ADDR_W-1:GRAN_LSB], 2) != $past(sc_addr[ADDR_W-1:GRAN_LSB]))));
endmodule

bind lrsc_tracker lrsc_tracker_chk #(
   .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .USE_EXT_KILL(USE_EXT_KILL)
) chk_i (.*);

// File: tb/lrsc_tracker_tb_top.sv
`timescale 1ns/1ps
module lrsc_tracker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lr_fire = 1'b0;
   logic [31:0] lr_addr = '0;
   logic        sc_fire = 1'b0;
   logic [31:0] sc_addr = '0;
   logic        mode_chg = 1'b0;
   logic        ext_kill = 1'b0;
   logic        sc_resp_valid;
   logic        sc_fail;

   int    checks = 0;
   int    errors = 0;
   bit    done   = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   lrsc_tracker dut_i (
      .clk(clk), .rst_n(rst_n),
      .lr_fire(lr_fire), .lr_addr(lr_addr),
      .sc_fire(sc_fire), .sc_addr(sc_addr),
      .mode_chg(mode_chg), .ext_kill(ext_kill),
      .sc_resp_valid(sc_resp_valid), .sc_fail(sc_fail)
   );

   // behavioural reference: one reservation slot, words compared
   bit          ref_has;
   int unsigned ref_word;
   bit          ref_rv;
   bit          ref_rf;

   always @(posedge clk) begin
      if (!rst_n) begin
         ref_has = 0; ref_rv = 0; ref_rf = 1;
      end else begin
         ref_rv = sc_fire;
         if (sc_fire) ref_rf = !(ref_has && ref_word == (sc_addr >> 2));
         if (sc_fire || mode_chg || ext_kill) ref_has = 0;
         else if (lr_fire) begin
            ref_has = 1; ref_word = lr_addr >> 2;
         end
      end
   end

   // compared on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (sc_resp_valid !== ref_rv || (ref_rv && sc_fail !== ref_rf)) begin
            errors++;
            $display("FAIL %s (R9 model) valid/fail %0b/%0b expected %0b/%0b",
                     cur_req, sc_resp_valid, sc_fail, ref_rv, ref_rf);
         end
      end
   end

   task automatic clear_in();
      lr_fire = 0; sc_fire = 0; mode_chg = 0; ext_kill = 0;
   endtask

   task automatic do_lr(input logic [31:0] a, input logic mc);
      @(negedge clk);
      lr_fire = 1; lr_addr = a; mode_chg = mc;
      @(negedge clk);
      clear_in();
   endtask

   task automatic do_kill(input logic mc, input logic kl);
      @(negedge clk);
      mode_chg = mc; ext_kill = kl;
      @(negedge clk);
      clear_in();
   endtask

   task automatic do_sc(input logic [31:0] a, input logic exp_fail, input string req,
                        input logic with_lr, input logic [31:0] la);
      cur_req = req;
      @(negedge clk);
      sc_fire = 1; sc_addr = a; lr_fire = with_lr; lr_addr = la;
      @(negedge clk);
      clear_in();
      checks++;
      if (sc_resp_valid !== 1'b1 || sc_fail !== exp_fail) begin
         errors++;
         $display("FAIL %s sc 0x%0h valid/fail %0b/%0b expected 1/%0b",
                  req, a, sc_resp_valid, sc_fail, exp_fail);
      end
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      checks++;
      if (sc_resp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset valid %0b expected 0", sc_resp_valid);
      end
      do_sc(32'h100, 1, "R1", 0, 0);
      // R2
      do_lr(32'h200, 0); do_sc(32'h200, 0, "R2", 0, 0);
      // R8
      do_lr(32'h300, 0); do_sc(32'h303, 0, "R8", 0, 0);
      do_lr(32'h301, 0); do_sc(32'h304, 1, "R8", 0, 0);
      // R4
      do_lr(32'h400, 0); do_sc(32'h400, 0, "R4", 0, 0);
      do_sc(32'h400, 1, "R4", 0, 0);
      // R3 then R4
      do_lr(32'h500, 0); do_sc(32'h600, 1, "R3", 0, 0);
      do_sc(32'h500, 1, "R4", 0, 0);
      // R5
      do_lr(32'h700, 0); do_kill(1, 0); do_sc(32'h700, 1, "R5", 0, 0);
      // R6
      do_lr(32'h800, 1); do_sc(32'h800, 1, "R6", 0, 0);
      // R7
      do_lr(32'h900, 0); do_lr(32'hA00, 0); do_sc(32'h900, 1, "R7", 0, 0);
      do_lr(32'h900, 0); do_lr(32'hA00, 0); do_sc(32'hA00, 0, "R7", 0, 0);
      // R10
      do_lr(32'hB00, 0); do_kill(0, 1); do_sc(32'hB00, 1, "R10", 0, 0);
      // R11
      do_lr(32'hC00, 0); do_sc(32'hC00, 0, "R11", 1, 32'hD00);
      do_sc(32'hD00, 1, "R11", 0, 0);
      // R9: idle cycle carries no result
      cur_req = "R9";
      @(negedge clk);
      checks++;
      if (sc_resp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R9 idle valid %0b expected 0", sc_resp_valid);
      end
      repeat (2) @(negedge clk);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule